// File: doc/BRIEF.md
# Multiplied Pulse Count Corrector

This block keeps a running count of multiplied-clock pulses in step with the number of reference edges that have arrived. Each reference edge arrives as a one-cycle capture strobe. An internal edge counter tracks these strobes. On every strobe, a target register is loaded with the current edge count scaled by a selectable factor of 32, 64, 128 or 256.

A correction counter advances on each multiplied-clock pulse strobe. When stop mode is enabled, the correction counter freezes once it equals the target. Any surplus pulses that a fast multiplier produces inside one reference period are therefore swallowed. A gated copy of the pulse strobe is forwarded only for pulses that were counted. A synchronous clear returns all three counters to zero.

Top module: `pulse_count_corrector`

## Requirements
- R1: After reset or a cycle with `clr` high, the edge counter, the target and the correction count are all 0. `clr` overrides a capture and a pulse in the same cycle.
- R2: On a capture strobe, the target is loaded with the edge count before that strobe, shifted left by 5 + `mul_sel`. The `mul_sel` values 0, 1, 2 and 3 give factors of 32, 64, 128 and 256.
- R3: Each capture strobe increments the edge counter by one.
- R4: When not halted, each cycle with `pls_stb` high increments `cnt_o` by one in the next cycle. Without `pls_stb`, `cnt_o` holds.
- R5: The counter is halted when `stop_en` is 1 and `cnt_o` equals the target. While halted, `cnt_o` does not advance.
- R6: With `stop_en` at 0, the count ignores the target and wraps from 16'hFFFF to 0.
- R7: `pls_o` equals `pls_stb` in any cycle where the counter is not halted. It is 0 in any cycle where the counter is halted.
- R8: When a capture and a pulse fall in the same cycle, that pulse is judged against the target held before the capture. The new target applies from the next cycle.
- R9: The scaled product is truncated to 16 bits. For example, an edge count of 256 with factor 256 loads a target of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| cap_stb | input | 1 | Reference edge (capture) strobe |
| pls_stb | input | 1 | Multiplied-clock pulse strobe |
| mul_sel | input | 2 | Multiplier select: factor 2^(5+mul_sel) |
| stop_en | input | 1 | Enable halting at the target |
| cnt_o | output | 16 | Corrected pulse count |
| pls_o | output | 1 | Pulse strobe, gated by the halt condition |

## Verification
A capture strobe and a pulse strobe can arrive in the same cycle. In that cycle, the target update and the halt decision compete. The bench sets up a halted state (count 0, target 0, edge count 1) and then raises both strobes together. The pulse must be suppressed on `pls_o` and must leave `cnt_o` at 0, because it is judged against the old target. A following lone pulse must advance the count, which shows that the new target of 32 has taken effect. A clear that arrives together with both strobes is also provoked, and it must win.

// File: rtl/pulse_count_corrector.sv
module pulse_count_corrector #(
  parameter int W          = 16,
  parameter int SHIFT_BASE = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         cap_stb,
  input  logic         pls_stb,
  input  logic [1:0]   mul_sel,
  input  logic         stop_en,
  output logic [W-1:0] cnt_o,
  output logic         pls_o
);

  logic [W-1:0] edge_q, tgt_q, cnt_q, product;
  logic         halted;

  assign product = edge_q << (SHIFT_BASE + int'(mul_sel));
  assign halted  = stop_en && (cnt_q == tgt_q);
  assign pls_o   = pls_stb && !halted;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      edge_q <= '0;
      tgt_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (cap_stb) begin
        tgt_q  <= product;
        edge_q <= edge_q + 1'b1;
      end
      if (pls_o) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int W          = 16,
  parameter int SHIFT_BASE = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         cap_stb,
  input logic         pls_stb,
  input logic [1:0]   mul_sel,
  input logic         stop_en,
  input logic [W-1:0] cnt_o,
  input logic         pls_o,
  input logic [W-1:0] edge_q,
  input logic [W-1:0] tgt_q
);

  logic [W-1:0] scaled;
  logic         at_tgt;
  assign scaled = edge_q << (SHIFT_BASE + int'(mul_sel));
  assign at_tgt = stop_en && (cnt_o == tgt_q);

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_o == '0 && tgt_q == '0 && edge_q == '0));

  // R2
  target_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cap_stb) |=> tgt_q == $past(scaled));

  // R3
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cap_stb) |=> edge_q == $past(edge_q) + 1'b1);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && pls_stb && !at_tgt) |=> cnt_o == $past(cnt_o) + 1'b1);

  // R4
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pls_stb) |=> $stable(cnt_o));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && at_tgt) |=> $stable(cnt_o));

  // R7
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pls_o == (pls_stb && !at_tgt));

endmodule

bind pulse_count_corrector pcc_checker #(.W(W), .SHIFT_BASE(SHIFT_BASE)) u_chk (.*);

// File: tb/pulse_count_corrector_tb.sv
module pulse_count_corrector_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        cap_stb = 1'b0;
  logic        pls_stb = 1'b0;
  logic [1:0]  mul_sel = 2'd0;
  logic        stop_en = 1'b0;
  logic [15:0] cnt_o;
  logic        pls_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pulse_count_corrector u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one cycle of stimulus; returns pls_o seen before the edge
  task automatic cyc(input logic c, input logic p, output logic po);
    cap_stb = c; pls_stb = p;
    #1 po = pls_o;
    @(posedge clk); #1;
    cap_stb = 1'b0; pls_stb = 1'b0;
  endtask

  task automatic do_clear();
    logic po;
    clr = 1'b1;
    cyc(1'b0, 1'b0, po);
    clr = 1'b0;
  endtask

  task automatic pulses(input int n, output int fwd);
    logic po;
    fwd = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b1, po);
      if (po) fwd++;
    end
  endtask

  task automatic capture(input logic [1:0] s);
    logic po;
    mul_sel = s;
    cyc(1'b1, 1'b0, po);
  endtask

  task automatic t_reset();
    logic po;
    chk("R1 reset count", cnt_o, 0);
    stop_en = 1'b1;
    cyc(1'b0, 1'b1, po);
    chk("R7 halted at reset, pls_o", po, 0);
    chk("R5 halted at reset, count", cnt_o, 0);
    stop_en = 1'b0;
  endtask

  task automatic t_free_count();
    int fwd;
    do_clear();
    stop_en = 1'b0;
    pulses(37, fwd);
    chk("R4 free count", cnt_o, 37);
    chk("R7 all forwarded", fwd, 37);
    #16;
    chk("R4 holds without pulses", cnt_o, 37);
  endtask

  task automatic t_stop_scaling();
    int fwd;
    do_clear();
    stop_en = 1'b1;
    capture(2'd0);
    capture(2'd0);
    pulses(40, fwd);
    chk("R2/R5 stop at 1*32", cnt_o, 32);
    chk("R7 forwarded up to 32", fwd, 32);
    capture(2'd1);
    pulses(200, fwd);
    chk("R2/R3 stop at 2*64", cnt_o, 128);
    chk("R7 forwarded 96", fwd, 96);
    capture(2'd2);
    pulses(300, fwd);
    chk("R2/R3 stop at 3*128", cnt_o, 384);
    capture(2'd3);
    pulses(700, fwd);
    chk("R2/R3 stop at 4*256", cnt_o, 1024);
    chk("R7 forwarded 640", fwd, 640);
  endtask

  task automatic t_truncate();
    int fwd;
    do_clear();
    stop_en = 1'b1;
    for (int i = 0; i < 256; i++) capture(2'd0);
    capture(2'd3);
    pulses(5, fwd);
    chk("R9 target 256*256 truncates to 0", cnt_o, 0);
    chk("R9 pulses suppressed", fwd, 0);
  endtask

  task automatic t_same_cycle();
    logic po;
    int fwd;
    do_clear();
    stop_en = 1'b1;
    capture(2'd0);
    mul_sel = 2'd0;
    cyc(1'b1, 1'b1, po);
    chk("R8 pulse judged on old target, pls_o", po, 0);
    chk("R8 pulse judged on old target, count", cnt_o, 0);
    pulses(1, fwd);
    chk("R8 new target applies next cycle", cnt_o, 1);
  endtask

  task automatic t_clear_priority();
    logic po;
    int fwd;
    do_clear();
    stop_en = 1'b0;
    pulses(10, fwd);
    for (int i = 0; i < 3; i++) capture(2'd0);
    clr = 1'b1;
    cyc(1'b1, 1'b1, po);
    clr = 1'b0;
    chk("R1 clear wins over pulse", cnt_o, 0);
    stop_en = 1'b1;
    pulses(3, fwd);
    chk("R1 target cleared, halted", cnt_o, 0);
    capture(2'd0);
    capture(2'd0);
    pulses(50, fwd);
    chk("R1/R3 edge counter cleared", cnt_o, 32);
  endtask

  task automatic t_wrap();
    int fwd;
    do_clear();
    stop_en = 1'b0;
    capture(2'd0);
    capture(2'd0);
    pulses(65535, fwd);
    chk("R6 ignores target, reaches max", cnt_o, 65535);
    pulses(1, fwd);
    chk("R6 wraps to zero", cnt_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_free_count();
    t_stop_scaling();
    t_truncate();
    t_same_cycle();
    t_clear_priority();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule